// File: doc/BRIEF.md
# AGC Output Word-Length Clipper

This block sits behind the gain multiplier of an automatic gain control loop. Each cycle it may accept one complex sample, a signed 19-bit I value and a signed 19-bit Q value, and it narrows both to one of eight programmable output widths by saturating them. The narrowed samples leave the block sign-extended to 16 bits, so one port width serves every setting.

The same datapath also measures how much was cut off. For each path it forms the difference between the sample as it arrived and the narrowed sample, taken back to 19 bits. A mode input selects what the AGC loop regulates. In plain mode the loop sees the scaled samples and settles on a signal level. In clipping-error mode it sees the truncation errors and settles on a clipping level. The selected pair leaves on dedicated magnitude-path outputs, beside a flag that names the active source.

All results are registered and have one cycle of latency. A valid strobe travels alongside them.

Top module: `agc_wordlen_clipper`

## Requirements
- R1: The 3-bit width select maps codes 0, 1, 2, 3, 4, 5, 6 and 7 to output widths of 4, 5, 6, 7, 8, 10, 12 and 16 bits.
- R2: A sample within [-2^(N-1), 2^(N-1)-1] for the selected width N appears unchanged on the narrowed output, sign-extended to 16 bits, and its error term is zero.
- R3: A sample above 2^(N-1)-1 produces exactly 2^(N-1)-1 on the narrowed output.
- R4: A sample below -2^(N-1) produces exactly -2^(N-1) on the narrowed output.
- R5: Each 19-bit signed error output equals the input sample minus the narrowed sample, with the narrowed sample sign-extended to 19 bits. I and Q are computed separately.
- R6: When the mode input is 1, the magnitude-path outputs carry the error terms and the source flag is 1. When it is 0, they carry the unmodified input samples and the flag is 0.
- R7: Every output reflects the inputs sampled at the previous rising clock edge, and the output valid is the input valid delayed by exactly one cycle.
- R8: A cycle with the input valid low leaves all data outputs and the source flag at their previous values.
- R9: While the active-low reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_i_i | input | 19 | Scaled I sample, signed |
| in_q_i | input | 19 | Scaled Q sample, signed |
| wl_sel_i | input | 3 | Output width select code |
| clip_mode_i | input | 1 | 1 selects the error terms for the magnitude path |
| out_valid_o | output | 1 | Output strobe, one cycle after the input strobe |
| out_i_o | output | 16 | Narrowed I, sign-extended |
| out_q_o | output | 16 | Narrowed Q, sign-extended |
| err_i_o | output | 19 | I truncation error, signed |
| err_q_o | output | 19 | Q truncation error, signed |
| mag_i_o | output | 19 | I value toward the magnitude path |
| mag_q_o | output | 19 | Q value toward the magnitude path |
| err_src_o | output | 1 | 1 when the magnitude path carries error terms |

## Verification
Every result is due one cycle after the rising edge that samples a valid input. Nothing changes after an edge with the strobe low. The bench drives inputs at the falling edge. After each rising edge, its reference model advances on exactly what was presented at that edge. The bench compares the outputs at the next falling edge, one register after the inputs and clear of any edge. The sweep places samples on both sides of each saturation limit for all eight codes and in both modes, so off-by-one limits and a swapped width table show up as value mismatches.

// File: rtl/agc_clip_pkg.sv
package agc_clip_pkg;
    localparam int SAMPLE_W  = 19;
    localparam int NARROW_W  = 16;
    localparam int SEL_W     = 3;
    localparam int WCNT_W    = $clog2(NARROW_W + 1);
    localparam int NUM_PATHS = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [NARROW_W-1:0] narrow_t;

    typedef struct packed {
        logic                                 valid;
        logic [NUM_PATHS-1:0][NARROW_W-1:0]   nar;
        logic [NUM_PATHS-1:0][SAMPLE_W-1:0]   err;
        logic [NUM_PATHS-1:0][SAMPLE_W-1:0]   mag;
        logic                                 err_src;
    } clip_state_t;
endpackage

// File: rtl/agc_wl_decode.sv
module agc_wl_decode #(
    parameter int SEL_W  = 3,
    parameter int WCNT_W = 5
) (
    input  logic [SEL_W-1:0]  sel_i,
    output logic [WCNT_W-1:0] width_o
);
    // Codes step by one bit up to 8, then by two bits, then jump to 16.
    always_comb begin
        case (sel_i)
            3'd0:    width_o = WCNT_W'(4);
            3'd1:    width_o = WCNT_W'(5);
            3'd2:    width_o = WCNT_W'(6);
            3'd3:    width_o = WCNT_W'(7);
            3'd4:    width_o = WCNT_W'(8);
            3'd5:    width_o = WCNT_W'(10);
            3'd6:    width_o = WCNT_W'(12);
            default: width_o = WCNT_W'(16);
        endcase
    end
endmodule

// File: rtl/agc_sat_path.sv
module agc_sat_path #(
    parameter int IN_W   = 19,
    parameter int OUT_W  = 16,
    parameter int WCNT_W = 5
) (
    input  logic signed [IN_W-1:0]  smp_i,
    input  logic [WCNT_W-1:0]       width_i,
    output logic signed [OUT_W-1:0] nar_o,
    output logic signed [IN_W-1:0]  err_o
);
    logic signed [IN_W-1:0] lim_hi;
    logic signed [IN_W-1:0] lim_lo;
    logic signed [IN_W-1:0] sat_full;

    always_comb begin
        lim_hi = $signed((IN_W'(1) << (width_i - WCNT_W'(1))) - IN_W'(1));
        lim_lo = ~lim_hi;
        if (smp_i > lim_hi) begin
            sat_full = lim_hi;
        end else if (smp_i < lim_lo) begin
            sat_full = lim_lo;
        end else begin
            sat_full = smp_i;
        end
        // The saturated value fits the widest setting, so dropping the upper bits keeps its sign.
        nar_o = sat_full[OUT_W-1:0];
        err_o = smp_i - sat_full;
    end
endmodule

// File: rtl/agc_src_mux.sv
module agc_src_mux #(
    parameter int W = 19
) (
    input  logic         use_err_i,
    input  logic [W-1:0] smp_i,
    input  logic [W-1:0] err_i,
    output logic [W-1:0] mag_o
);
    always_comb begin
        mag_o = use_err_i ? err_i : smp_i;
    end
endmodule

// File: rtl/agc_wordlen_clipper.sv
module agc_wordlen_clipper
    import agc_clip_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  logic [SAMPLE_W-1:0] in_i_i,
    input  logic [SAMPLE_W-1:0] in_q_i,
    input  logic [SEL_W-1:0]    wl_sel_i,
    input  logic                clip_mode_i,
    output logic                out_valid_o,
    output logic [NARROW_W-1:0] out_i_o,
    output logic [NARROW_W-1:0] out_q_o,
    output logic [SAMPLE_W-1:0] err_i_o,
    output logic [SAMPLE_W-1:0] err_q_o,
    output logic [SAMPLE_W-1:0] mag_i_o,
    output logic [SAMPLE_W-1:0] mag_q_o,
    output logic                err_src_o
);
    logic [WCNT_W-1:0]                  width;
    logic [NUM_PATHS-1:0][SAMPLE_W-1:0] smp;
    logic [NUM_PATHS-1:0][NARROW_W-1:0] nar_c;
    logic [NUM_PATHS-1:0][SAMPLE_W-1:0] err_c;
    logic [NUM_PATHS-1:0][SAMPLE_W-1:0] mag_c;
    clip_state_t                        st_d;
    clip_state_t                        st_q;

    assign smp[0] = in_i_i;
    assign smp[1] = in_q_i;

    agc_wl_decode #(
        .SEL_W (SEL_W),
        .WCNT_W(WCNT_W)
    ) i_decode (
        .sel_i  (wl_sel_i),
        .width_o(width)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        logic signed [NARROW_W-1:0] nar_s;
        logic signed [SAMPLE_W-1:0] err_s;

        agc_sat_path #(
            .IN_W  (SAMPLE_W),
            .OUT_W (NARROW_W),
            .WCNT_W(WCNT_W)
        ) i_sat (
            .smp_i  ($signed(smp[p])),
            .width_i(width),
            .nar_o  (nar_s),
            .err_o  (err_s)
        );

        assign nar_c[p] = nar_s;
        assign err_c[p] = err_s;

        agc_src_mux #(
            .W(SAMPLE_W)
        ) i_mux (
            .use_err_i(clip_mode_i),
            .smp_i    (smp[p]),
            .err_i    (err_c[p]),
            .mag_o    (mag_c[p])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            st_d.nar     = nar_c;
            st_d.err     = err_c;
            st_d.mag     = mag_c;
            st_d.err_src = clip_mode_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign out_i_o     = st_q.nar[0];
    assign out_q_o     = st_q.nar[1];
    assign err_i_o     = st_q.err[0];
    assign err_q_o     = st_q.err[1];
    assign mag_i_o     = st_q.mag[0];
    assign mag_q_o     = st_q.mag[1];
    assign err_src_o   = st_q.err_src;
endmodule

// File: rtl/agc_clip_checker.sv
module agc_clip_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        in_valid_i,
    input logic [18:0] in_i_i,
    input logic [18:0] in_q_i,
    input logic [2:0]  wl_sel_i,
    input logic        clip_mode_i,
    input logic        out_valid_o,
    input logic [15:0] out_i_o,
    input logic [15:0] out_q_o,
    input logic [18:0] err_i_o,
    input logic [18:0] err_q_o,
    input logic [18:0] mag_i_o,
    input logic [18:0] mag_q_o,
    input logic        err_src_o
);
    function automatic int top_of(logic [2:0] code);
        int w;
        case (code)
            3'd0: w = 4;   3'd1: w = 5;   3'd2: w = 6;  3'd3: w = 7;
            3'd4: w = 8;   3'd5: w = 10;  3'd6: w = 12; default: w = 16;
        endcase
        return (1 << (w - 1)) - 1;
    endfunction

    assert_valid_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
    assert_valid_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(out_i_o) && $stable(out_q_o) && $stable(err_i_o)
                         && $stable(err_q_o) && $stable(mag_i_o) && $stable(mag_q_o)
                         && $stable(err_src_o)));

    assert_err_sum_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (int'($signed(err_i_o)) + int'($signed(out_i_o)) == int'($signed($past(in_i_i)))
                     && int'($signed(err_q_o)) + int'($signed(out_q_o)) == int'($signed($past(in_q_i)))));

    assert_upper_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> int'($signed(out_i_o)) <= top_of($past(wl_sel_i))
                    && int'($signed(out_q_o)) <= top_of($past(wl_sel_i)));

    assert_lower_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> int'($signed(out_i_o)) >= -top_of($past(wl_sel_i)) - 1
                    && int'($signed(out_q_o)) >= -top_of($past(wl_sel_i)) - 1);

    assert_inrange_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && int'($signed(in_i_i)) <= top_of(wl_sel_i)
                    && int'($signed(in_i_i)) >= -top_of(wl_sel_i) - 1) |=> err_i_o == '0);

    assert_mag_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && clip_mode_i) |=> (mag_i_o == err_i_o && mag_q_o == err_q_o && err_src_o));

    assert_mag_smp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && !clip_mode_i) |=> (mag_i_o == $past(in_i_i) && mag_q_o == $past(in_q_i) && !err_src_o));
endmodule

bind agc_wordlen_clipper agc_clip_checker i_chk (.*);

// File: tb/test_agc_wordlen_clipper.sv
module test_agc_wordlen_clipper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [18:0] in_i = '0;
    logic [18:0] in_q = '0;
    logic [2:0]  wl_sel = '0;
    logic        clip_mode = 1'b0;
    logic        out_valid;
    logic [15:0] out_i, out_q;
    logic [18:0] err_i, err_q, mag_i, mag_q;
    logic        err_src;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    int  e_oi = 0, e_oq = 0, e_ei = 0, e_eq = 0, e_mi = 0, e_mq = 0, e_src = 0, e_val = 0;
    string t_i = "R9", t_q = "R9", t_e = "R9", t_m = "R9";

    always #(CLK_PERIOD / 2) clk = ~clk;

    agc_wordlen_clipper i_agc_wordlen_clipper (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .in_valid_i (in_valid),
        .in_i_i     (in_i),
        .in_q_i     (in_q),
        .wl_sel_i   (wl_sel),
        .clip_mode_i(clip_mode),
        .out_valid_o(out_valid),
        .out_i_o    (out_i),
        .out_q_o    (out_q),
        .err_i_o    (err_i),
        .err_q_o    (err_q),
        .mag_i_o    (mag_i),
        .mag_q_o    (mag_q),
        .err_src_o  (err_src)
    );

    function automatic int width_of(int code);   // R1 table
        int tbl[8] = '{4, 5, 6, 7, 8, 10, 12, 16};
        return tbl[code];
    endfunction

    function automatic int hi_of(int w);
        return (1 << (w - 1)) - 1;
    endfunction

    function automatic int sat(int x, int w);
        if (x > hi_of(w)) return hi_of(w);
        if (x < -hi_of(w) - 1) return -hi_of(w) - 1;
        return x;
    endfunction

    function automatic string cls(int x, int w);
        if (x > hi_of(w)) return "R3";
        if (x < -hi_of(w) - 1) return "R4";
        return "R2";
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R7", int'(out_valid), e_val);
        chk(t_i, int'($signed(out_i)), e_oi);
        chk(t_q, int'($signed(out_q)), e_oq);
        chk(t_e, int'($signed(err_i)), e_ei);
        chk(t_e, int'($signed(err_q)), e_eq);
        chk(t_m, int'($signed(mag_i)), e_mi);
        chk(t_m, int'($signed(mag_q)), e_mq);
        chk(t_m, int'(err_src), e_src);
    endtask

    task automatic step(bit v, int si, int sq, int sel, bit m);
        int w;
        in_valid  = v;
        in_i      = 19'(si);
        in_q      = 19'(sq);
        wl_sel    = 3'(sel);
        clip_mode = m;
        @(posedge clk);
        e_val = v;
        if (v) begin
            w     = width_of(sel);
            e_oi  = sat(si, w);
            e_oq  = sat(sq, w);
            e_ei  = si - e_oi;
            e_eq  = sq - e_oq;
            e_mi  = m ? e_ei : si;
            e_mq  = m ? e_eq : sq;
            e_src = m;
            t_i   = cls(si, w);
            t_q   = cls(sq, w);
            t_e   = "R5";
            t_m   = "R6";
        end else begin
            t_i = "R8"; t_q = "R8"; t_e = "R8"; t_m = "R8";
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int hv;
        repeat (3) @(negedge clk);
        compare_all();                      // R9 reset state, all zero
        in_valid = 1'b1; in_i = 19'(1000); in_q = 19'(-1000); clip_mode = 1'b1;
        @(negedge clk);
        compare_all();                      // R9 inputs ignored while in reset
        rst_n = 1'b1;

        for (int sel = 0; sel < 8; sel++) begin
            for (int m = 0; m < 2; m++) begin
                hv = hi_of(width_of(sel));
                step(1, hv, -hv - 1, sel, m[0]);
                step(1, hv + 1, -hv - 2, sel, m[0]);
                step(1, 262143, -262144, sel, m[0]);
                chk("R1", int'($signed(out_i)), hi_of(width_of(sel)));
                chk("R1", int'($signed(out_q)), -hi_of(width_of(sel)) - 1);
                step(1, 3, -5, sel, m[0]);
                step(1, -262144, 262143, sel, m[0]);
            end
        end

        // R8: strobe low with changing inputs leaves outputs untouched
        step(1, 50000, -70000, 2, 1'b1);
        step(0, 1000, -1000, 7, 1'b0);
        step(0, -7, 9, 0, 1'b1);
        step(0, 262143, 0, 5, 1'b0);
        step(1, 20, -20, 7, 1'b0);

        // R7: alternating strobe
        for (int k = 0; k < 20; k++) begin
            step(k[0], k * 977 - 9000, 9000 - k * 313, k % 8, k[1]);
        end

        for (int k = 0; k < 400; k++) begin
            step(($urandom_range(0, 3) != 0),
                 int'($urandom_range(0, 524287)) - 262144,
                 int'($urandom_range(0, 524287)) - 262144,
                 int'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)));
        end

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule